// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Interface

This block takes configuration words for a two-channel frequency synthesizer. A host sends them over three asynchronous wires: a serial data line, a serial clock and a load strobe. Each of the three wires is brought into the system clock domain through a synchroniser. Each rising edge of the serial clock shifts one bit into a 23-bit shift register, most significant bit first. A rising edge of the load strobe copies the register into one of four latches. The two bits shifted last form a tag, and the tag picks the latch: the reference-divider latch or the main-divider latch, for channel 0 or channel 1.

Reference words are 18 bits long and main-divider words are 23 bits long. Both kinds use the same register. Because the tag is always at the tail, every field is aligned to the low end of the register. Any bits shifted in earlier than the word are ignored. The latched fields go straight out to the divider logic: reference ratio, test-select pair, main counter value, swallow value, prescaler-modulus select, phase polarity and output-mux select. A write that carries a reference ratio or main counter value below the legal minimum is dropped. That rejected write raises a sticky error flag.

Top module: `serial_prog_if`

## Requirements
- R1: On each rising edge of `ser_clk_i` the register shifts one place toward the high end, and the synchronised `ser_data_i` enters at bit 0. Words are therefore sent MSB first. Only the most recently shifted 23 bits (18 bits for a reference word) matter, and any bits sent earlier are ignored.
- R2: On a load, register bit 1 selects the latch kind (0 = reference, 1 = main divider) and register bit 0 selects the channel (0 or 1). Only the selected latch changes.
- R3: For a reference word, bits 17:4 hold the reference ratio and go to `ref_div_o[ch]`. Bits 3:2 go to `test_sel_o[ch]`, with bit 2 mapping to `test_sel_o[ch][0]`.
- R4: For a main word, the fields map as follows:
  - bits 22:12 hold the counter value, which goes to `main_n_o[ch]`;
  - bits 11:5 hold the swallow value, which goes to `swallow_o[ch]`;
  - bit 4 goes to `pol_o[ch]`;
  - bit 3 goes to `mod_sel_o[ch]`;
  - bit 2 goes to `mux_sel_o[ch]`.
- R5: Exactly one latch update happens per rising edge of `ser_le_i`. Holding the strobe high while more bits are shifted in causes no further update. Shifting with the strobe low changes no output.
- R6: A reference write with ratio below 5, or a main write with counter value below 5, leaves the whole target latch unchanged. It also sets `err_o`, which stays set until reset. Latched ratios are never below 5.
- R7: After reset every reference ratio and counter value is 5. Swallow values, test selects, modulus selects and mux selects are 0, polarity is 1, and `err_o` is 0.
- R8: The following values are all accepted and latched unchanged: reference ratio 5 and 16383, counter value 5 and 2047, and swallow value 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_data_i | input | 1 | Serial data (asynchronous) |
| ser_le_i | input | 1 | Load strobe (asynchronous) |
| ref_div_o | output | 2x14 | Reference ratio per channel |
| test_sel_o | output | 2x2 | Test-select pair per channel |
| main_n_o | output | 2x11 | Main counter value per channel |
| swallow_o | output | 2x7 | Swallow value per channel |
| mod_sel_o | output | 2 | Prescaler-modulus select per channel |
| pol_o | output | 2 | Phase polarity per channel |
| mux_sel_o | output | 2 | Output-mux select per channel |
| err_o | output | 1 | Sticky illegal-ratio flag |

## Verification
The bench goes after field alignment with both word lengths. It sends an 18-bit reference word over leftover main-word bits, and it sends extra leading bits before a main word. A design that aligned fields to the high end of the register would latch shifted garbage in both cases. The bench also keeps the load strobe high while shifting a second word. A level-sensitive load would then write the second word into the other channel. Rejected ratios of 4 are placed next to the accepted extremes of 5, 2047 and 16383. Off-by-one limits or a partial write of a rejected main word would show up as wrong values, and a non-sticky error flag would show up in the writes that follow.

// File: rtl/serial_prog_pkg.sv
`timescale 1ns/1ps
package serial_prog_pkg;
  typedef enum logic [1:0] {
    DST_REF0  = 2'b00,
    DST_REF1  = 2'b01,
    DST_MAIN0 = 2'b10,
    DST_MAIN1 = 2'b11
  } dest_e;
endpackage

// File: rtl/sync_vec.sv
`timescale 1ns/1ps
module sync_vec #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/shift_reg.sv
`timescale 1ns/1ps
module shift_reg #(
  parameter int W = 23
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else if (en_i) q_o <= {q_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/chan_latch.sv
`timescale 1ns/1ps
module chan_latch #(
  parameter int REF_W     = 14,
  parameter int N_W       = 11,
  parameter int A_W       = 7,
  parameter int MIN_RATIO = 5,
  localparam int RP_W     = REF_W + 2,
  localparam int MP_W     = 3 + A_W + N_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_we_i,
  input  logic             main_we_i,
  input  logic [RP_W-1:0]  ref_pay_i,
  input  logic [MP_W-1:0]  main_pay_i,
  output logic [REF_W-1:0] ref_div_o,
  output logic [1:0]       test_sel_o,
  output logic [N_W-1:0]   main_n_o,
  output logic [A_W-1:0]   swallow_o,
  output logic             mod_sel_o,
  output logic             pol_o,
  output logic             mux_sel_o,
  output logic             rej_o
);
  localparam logic [REF_W-1:0] R_MIN = REF_W'(MIN_RATIO);
  localparam logic [N_W-1:0]   N_MIN = N_W'(MIN_RATIO);

  logic [REF_W-1:0] r_in;
  logic [1:0]       t_in;
  logic [N_W-1:0]   n_in;
  logic [A_W-1:0]   a_in;
  logic             ref_bad, main_bad;

  assign t_in = ref_pay_i[1:0];
  assign r_in = ref_pay_i[2 +: REF_W];
  assign n_in = main_pay_i[3+A_W +: N_W];
  assign a_in = main_pay_i[3 +: A_W];

  assign ref_bad  = r_in < R_MIN;
  assign main_bad = n_in < N_MIN;
  assign rej_o    = (ref_we_i && ref_bad) || (main_we_i && main_bad);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_div_o  <= R_MIN;
      test_sel_o <= '0;
    end else if (ref_we_i && !ref_bad) begin
      ref_div_o  <= r_in;
      test_sel_o <= t_in;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_n_o  <= N_MIN;
      swallow_o <= '0;
      pol_o     <= 1'b1;
      mod_sel_o <= 1'b0;
      mux_sel_o <= 1'b0;
    end else if (main_we_i && !main_bad) begin
      main_n_o  <= n_in;
      swallow_o <= a_in;
      pol_o     <= main_pay_i[2];
      mod_sel_o <= main_pay_i[1];
      mux_sel_o <= main_pay_i[0];
    end
  end
endmodule

// File: rtl/serial_prog_if.sv
`timescale 1ns/1ps
module serial_prog_if
  import serial_prog_pkg::*;
#(
  parameter int REF_W       = 14,
  parameter int N_W         = 11,
  parameter int A_W         = 7,
  parameter int MIN_RATIO   = 5,
  parameter int SYNC_STAGES = 2,
  localparam int NCH        = 2,
  localparam int SR_W       = 5 + A_W + N_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ser_clk_i,
  input  logic                      ser_data_i,
  input  logic                      ser_le_i,
  output logic [NCH-1:0][REF_W-1:0] ref_div_o,
  output logic [NCH-1:0][1:0]       test_sel_o,
  output logic [NCH-1:0][N_W-1:0]   main_n_o,
  output logic [NCH-1:0][A_W-1:0]   swallow_o,
  output logic [NCH-1:0]            mod_sel_o,
  output logic [NCH-1:0]            pol_o,
  output logic [NCH-1:0]            mux_sel_o,
  output logic                      err_o
);
  logic [2:0]      pin_s;
  logic            sclk_s, data_s, le_s;
  logic            sclk_d, le_d;
  logic            bit_stb, load_stb;
  logic [SR_W-1:0] sr_q;
  dest_e           dest;
  logic [NCH-1:0]  ref_we, main_we, rej;

  sync_vec #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ser_le_i, ser_data_i, ser_clk_i}),
    .q_o   (pin_s)
  );
  assign sclk_s = pin_s[0];
  assign data_s = pin_s[1];
  assign le_s   = pin_s[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      le_d   <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      le_d   <= le_s;
    end
  end
  assign bit_stb  = sclk_s & ~sclk_d;
  assign load_stb = le_s & ~le_d;

  shift_reg #(.W(SR_W)) u_sr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (bit_stb),
    .bit_i (data_s),
    .q_o   (sr_q)
  );

  // tag is the last-shifted pair, so it sits at the low end
  assign dest = dest_e'(sr_q[1:0]);
  always_comb begin
    ref_we  = '0;
    main_we = '0;
    if (load_stb) begin
      case (dest)
        DST_REF0:  ref_we[0]  = 1'b1;
        DST_REF1:  ref_we[1]  = 1'b1;
        DST_MAIN0: main_we[0] = 1'b1;
        default:   main_we[1] = 1'b1;
      endcase
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chan_latch #(
      .REF_W(REF_W), .N_W(N_W), .A_W(A_W), .MIN_RATIO(MIN_RATIO)
    ) u_lat (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ref_we_i  (ref_we[c]),
      .main_we_i (main_we[c]),
      .ref_pay_i (sr_q[2 +: REF_W+2]),
      .main_pay_i(sr_q[SR_W-1:2]),
      .ref_div_o (ref_div_o[c]),
      .test_sel_o(test_sel_o[c]),
      .main_n_o  (main_n_o[c]),
      .swallow_o (swallow_o[c]),
      .mod_sel_o (mod_sel_o[c]),
      .pol_o     (pol_o[c]),
      .mux_sel_o (mux_sel_o[c]),
      .rej_o     (rej[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else if (|rej) err_o <= 1'b1;
  end
endmodule

// File: rtl/serial_prog_chk.sv
`timescale 1ns/1ps
module serial_prog_chk #(
  parameter int REF_W     = 14,
  parameter int N_W       = 11,
  parameter int A_W       = 7,
  parameter int MIN_RATIO = 5,
  parameter int SR_W      = 23
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  bit_stb,
  input logic                  load_stb,
  input logic                  data_s,
  input logic [SR_W-1:0]       sr_q,
  input logic [1:0][REF_W-1:0] ref_div_o,
  input logic [1:0][1:0]       test_sel_o,
  input logic [1:0][N_W-1:0]   main_n_o,
  input logic [1:0][A_W-1:0]   swallow_o,
  input logic [1:0]            mod_sel_o,
  input logic [1:0]            pol_o,
  input logic [1:0]            mux_sel_o,
  input logic                  err_o
);
  p_shift_in_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb |=> sr_q[0] == $past(data_s));

  p_ref_dest_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_stb && sr_q[1]) |=> ($stable(ref_div_o) && $stable(test_sel_o)));

  p_main_dest_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_stb && !sr_q[1]) |=> ($stable(main_n_o) && $stable(swallow_o)
      && $stable(mod_sel_o) && $stable(pol_o) && $stable(mux_sel_o)));

  p_only_on_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_stb |=> ($stable(ref_div_o) && $stable(test_sel_o) && $stable(main_n_o)
      && $stable(swallow_o) && $stable(pol_o) && $stable(mod_sel_o) && $stable(mux_sel_o)));

  p_ratio_floor_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_div_o[0] >= REF_W'(MIN_RATIO) && ref_div_o[1] >= REF_W'(MIN_RATIO)
      && main_n_o[0] >= N_W'(MIN_RATIO) && main_n_o[1] >= N_W'(MIN_RATIO));

  p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind serial_prog_if serial_prog_chk #(
  .REF_W(REF_W), .N_W(N_W), .A_W(A_W), .MIN_RATIO(MIN_RATIO), .SR_W(SR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bit_stb   (bit_stb),
  .load_stb  (load_stb),
  .data_s    (data_s),
  .sr_q      (sr_q),
  .ref_div_o (ref_div_o),
  .test_sel_o(test_sel_o),
  .main_n_o  (main_n_o),
  .swallow_o (swallow_o),
  .mod_sel_o (mod_sel_o),
  .pol_o     (pol_o),
  .mux_sel_o (mux_sel_o),
  .err_o     (err_o)
);

// File: tb/sim_serial_prog_if.sv
`timescale 1ns/1ps
module sim_serial_prog_if;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, sle = 1'b0;
  logic [1:0][13:0] ref_div;
  logic [1:0][1:0]  test_sel;
  logic [1:0][10:0] main_n;
  logic [1:0][6:0]  swallow;
  logic [1:0]       mod_sel, pol, mux_sel;
  logic             err;

  always #4 clk = ~clk;

  serial_prog_if u0 (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_data_i(sdat), .ser_le_i(sle),
    .ref_div_o(ref_div), .test_sel_o(test_sel), .main_n_o(main_n), .swallow_o(swallow),
    .mod_sel_o(mod_sel), .pol_o(pol), .mux_sel_o(mux_sel), .err_o(err)
  );

  typedef struct packed {
    logic [1:0][13:0] r;
    logic [1:0][1:0]  t;
    logic [1:0][10:0] n;
    logic [1:0][6:0]  a;
    logic [1:0]       sw, fc, lds;
    logic             e;
  } snap_t;

  snap_t exp_s;
  snap_t exp_q[$];
  string tag_q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string tag, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // monitor: pops expected snapshots and compares the outputs
  initial begin
    forever begin
      wait (exp_q.size() > 0);
      @(negedge clk);
      begin
        snap_t s;
        string tg;
        s  = exp_q[0];
        tg = tag_q[0];
        for (int c = 0; c < 2; c++) begin
          chk(tg, $sformatf("ref_div[%0d]", c), int'(ref_div[c]), int'(s.r[c]));
          chk(tg, $sformatf("test_sel[%0d]", c), int'(test_sel[c]), int'(s.t[c]));
          chk(tg, $sformatf("main_n[%0d]", c), int'(main_n[c]), int'(s.n[c]));
          chk(tg, $sformatf("swallow[%0d]", c), int'(swallow[c]), int'(s.a[c]));
          chk(tg, $sformatf("mod_sel[%0d]", c), int'(mod_sel[c]), int'(s.sw[c]));
          chk(tg, $sformatf("pol[%0d]", c), int'(pol[c]), int'(s.fc[c]));
          chk(tg, $sformatf("mux_sel[%0d]", c), int'(mux_sel[c]), int'(s.lds[c]));
        end
        chk(tg, "err", int'(err), int'(s.e));
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  task automatic expect_now(string tag);
    exp_q.push_back(exp_s);
    tag_q.push_back(tag);
    wait (exp_q.size() == 0);
  endtask

  task automatic send_bits(input logic [22:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); sdat = w[i];
      repeat (4) @(negedge clk); sclk = 1'b1;
      repeat (4) @(negedge clk); sclk = 1'b0;
    end
  endtask

  task automatic pulse_le();
    repeat (2) @(negedge clk); sle = 1'b1;
    repeat (6) @(negedge clk); sle = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  function automatic logic [22:0] ref_word(int ch, int t, int r);
    logic [22:0] w;
    w = '0;
    w[17:4] = 14'(r); w[3:2] = 2'(t); w[1] = 1'b0; w[0] = 1'(ch);
    return w;
  endfunction

  function automatic logic [22:0] main_word(int ch, int lds, int sw, int fc, int a, int n);
    logic [22:0] w;
    w[22:12] = 11'(n); w[11:5] = 7'(a); w[4] = 1'(fc); w[3] = 1'(sw);
    w[2] = 1'(lds); w[1] = 1'b1; w[0] = 1'(ch);
    return w;
  endfunction

  // reference model of a load, from the requirements
  task automatic model_load(input logic [22:0] w);
    int ch;
    ch = int'(w[0]);
    if (!w[1]) begin
      if (w[17:4] < 14'd5) exp_s.e = 1'b1;
      else begin exp_s.r[ch] = w[17:4]; exp_s.t[ch] = w[3:2]; end
    end else begin
      if (w[22:12] < 11'd5) exp_s.e = 1'b1;
      else begin
        exp_s.n[ch] = w[22:12]; exp_s.a[ch] = w[11:5];
        exp_s.fc[ch] = w[4]; exp_s.sw[ch] = w[3]; exp_s.lds[ch] = w[2];
      end
    end
  endtask

  task automatic write_ref(int ch, int t, int r, string tag);
    logic [22:0] w;
    w = ref_word(ch, t, r);
    send_bits(w, 18); pulse_le(); model_load(w); expect_now(tag);
  endtask

  task automatic write_main(int ch, int lds, int sw, int fc, int a, int n, string tag);
    logic [22:0] w;
    w = main_word(ch, lds, sw, fc, a, n);
    send_bits(w, 23); pulse_le(); model_load(w); expect_now(tag);
  endtask

  initial begin
    logic [22:0] w;
    exp_s = '0;
    exp_s.r = {14'd5, 14'd5}; exp_s.n = {11'd5, 11'd5}; exp_s.fc = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_now("R7 reset");

    write_ref(0, 2, 1000, "R2 R3 ref ch0");
    write_ref(1, 1, 16383, "R3 R8 ref ch1 max");
    write_main(0, 1, 0, 0, 37, 300, "R4 main ch0");
    write_main(1, 0, 1, 1, 127, 2047, "R4 R8 main ch1 max");
    write_ref(0, 3, 4, "R6 ref ratio 4 rejected");
    write_main(1, 1, 0, 0, 9, 4, "R6 main ratio 4 rejected");
    write_ref(1, 0, 5, "R8 R6 ref ratio 5 accepted, err sticky");
    write_main(0, 0, 1, 1, 0, 5, "R8 main n 5 accepted");

    // R1: leading extra bits are discarded
    send_bits(23'h1f, 5);
    write_main(0, 0, 1, 1, 5, 1234, "R1 leading bits ignored");

    // R5: strobe held high while another word is shifted
    w = ref_word(0, 1, 777);
    send_bits(w, 18);
    repeat (2) @(negedge clk); sle = 1'b1;
    repeat (8) @(negedge clk);
    model_load(w);
    send_bits(ref_word(1, 2, 999), 18);
    sle = 1'b0;
    repeat (10) @(negedge clk);
    expect_now("R5 held strobe single update");

    // R5: shifting without strobe changes nothing
    send_bits(main_word(0, 1, 0, 0, 99, 1999), 23);
    repeat (10) @(negedge clk);
    expect_now("R5 no strobe no update");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule